// File: doc/BRIEF.md
# ASID-Tagged Two-Way Set-Associative Translation Buffer

This block caches recent virtual-to-physical page translations so that a load/store path can translate an address without walking page tables. A 32-bit virtual address is cut into a byte offset (12 bits for 4 KB pages) and a page number. The low page-number bits pick one of 256 sets, and the remaining high bits are a tag. Each set holds two ways. Each way stores a valid flag, an address-space identifier, a tag and a physical frame number.

A lookup is decided combinationally from the current contents. The result is registered, so hit, miss and the physical address appear on the clock after the request. An entry matches only when both its tag and its address-space identifier equal the request's. The same virtual address issued by two processes therefore lands on two separate entries.

When a lookup misses, an external walker supplies the frame through the fill port. The fill overwrites an entry that already holds the same set, tag and identifier. Otherwise it uses an empty way, or else the way named by the set's recency bit. A flush input empties the whole buffer in one cycle.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, every recency bit is zero, and `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_pa` are all zero. A lookup made right after reset misses.
- R2: A lookup accepted on a clock edge (`lk_valid` high) produces `rsp_valid` high on the following cycle, with exactly one of `rsp_hit` and `rsp_miss` high. A cycle without a lookup produces `rsp_valid`, `rsp_hit` and `rsp_miss` all low on the next cycle.
- R3: On a hit, `rsp_pa` equals the stored frame number shifted left by 12, ORed with bits [11:0] of the request address, so an offset of zero yields the frame base address. On a miss, `rsp_pa` is zero.
- R4: The set is VA[19:12] and the tag is VA[31:20]. An entry hits only for a request whose set and tag both equal its own. Addresses on opposite sides of a page boundary, such as 0x6FFF and 0x7000, never share an entry.
- R5: A hit also requires the request's identifier to equal the stored one. The same address under two identifiers resolves to two independent entries.
- R6: The fill port's page number is VA[31:12]. A fill whose set, tag and identifier match a valid entry rewrites that entry's frame in place. Otherwise the fill goes to the lowest-numbered invalid way of the set, or, if both ways are valid, to the way named by the set's recency bit. A request never matches more than one way.
- R7: The recency bit of a set holds the index of the way to replace next. A hit or a fill on way w sets it to the other way. When a hit and a fill touch the same set in one cycle, the fill's update wins. Misses leave it unchanged.
- R8: A flush clears every valid flag and every recency bit in one cycle. A fill presented in the same cycle as a flush is discarded.
- R9: A lookup presented in the same cycle as a fill or a flush is answered from the contents held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space identifier of the lookup |
| fill_valid | input | 1 | Fill request strobe |
| fill_vpn | input | 20 | Virtual page number being installed (VA[31:12]) |
| fill_asid | input | 8 | Address-space identifier of the fill |
| fill_pfn | input | 20 | Physical frame number being installed |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Registered: a lookup was made last cycle |
| rsp_hit | output | 1 | Registered: last lookup hit |
| rsp_miss | output | 1 | Registered: last lookup missed |
| rsp_pa | output | 32 | Registered physical address (zero on miss) |

## Verification
The bound checker watches properties that hold on every cycle:
- the response follows its request by exactly one cycle and is either a hit or a miss;
- the offset passes through untranslated on hits, and the address is zero on misses;
- no request ever matches two ways;
- every accepted fill targets exactly one way;
- a lookup made right after a flush cannot hit.

The behaviours that depend on history can only be shown by the bench's scenarios. These are the frame values returned, separation by identifier and by page boundary, in-place rewrite of a duplicate fill, recency-driven eviction after a hit has refreshed a way, and the before-the-edge view of a lookup that shares a cycle with a fill or flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int WAYS  = 2;
  localparam int WAY_W = 1;

  typedef logic [WAYS-1:0] way_vec_t;

  // One-hot target for a fill: existing match, else lowest empty way, else victim.
  function automatic way_vec_t pick_fill_way(way_vec_t match, way_vec_t valid,
                                             logic [WAY_W-1:0] victim);
    way_vec_t sel;
    sel = '0;
    if (|match) begin
      sel = match;
    end else if (&valid) begin
      sel[victim] = 1'b1;
    end else begin
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!valid[w]) sel = way_vec_t'(1) << w;
      end
    end
    return sel;
  endfunction

  // Encode a one-hot way vector into an index.
  function automatic logic [WAY_W-1:0] way_index(way_vec_t v);
    logic [WAY_W-1:0] idx;
    idx = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (v[w]) idx = WAY_W'(w);
    end
    return idx;
  endfunction

endpackage

// File: rtl/tlb_way.sv
module tlb_way #(
  parameter int SET_W  = 8,
  parameter int TAG_W  = 12,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_match,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              wr_match,
  output logic              wr_slot_valid
);

  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [ASID_W-1:0] asid_q [SETS];
  logic [PFN_W-1:0]  pfn_q  [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_set]  <= wr_tag;
      asid_q[wr_set] <= wr_asid;
      pfn_q[wr_set]  <= wr_pfn;
    end
  end

  always_comb begin
    lk_match = valid_q[lk_set] && (tag_q[lk_set] == lk_tag) && (asid_q[lk_set] == lk_asid);
    lk_pfn   = pfn_q[lk_set];
    wr_match = valid_q[wr_set] && (tag_q[wr_set] == wr_tag) && (asid_q[wr_set] == wr_asid);
    wr_slot_valid = valid_q[wr_set];
  end

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int SET_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      hit_en,
  input  logic [SET_W-1:0]          hit_set,
  input  logic [tlb_pkg::WAY_W-1:0] hit_way,
  input  logic                      fill_en,
  input  logic [SET_W-1:0]          fill_set,
  input  logic [tlb_pkg::WAY_W-1:0] fill_way,
  input  logic [SET_W-1:0]          rd_set,
  output logic [tlb_pkg::WAY_W-1:0] victim
);

  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] next_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      next_q <= '0;
    end else begin
      if (hit_en && !(fill_en && fill_set == hit_set)) next_q[hit_set] <= ~hit_way;
      if (fill_en) next_q[fill_set] <= ~fill_way;
    end
  end

  assign victim = next_q[rd_set];

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int SET_W  = 8,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  input  logic [VA_W-1:0]         lk_va,
  input  logic [ASID_W-1:0]       lk_asid,
  input  logic                    fill_valid,
  input  logic [VA_W-OFF_W-1:0]   fill_vpn,
  input  logic [ASID_W-1:0]       fill_asid,
  input  logic [PFN_W-1:0]        fill_pfn,
  input  logic                    flush,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic                    rsp_miss,
  output logic [PFN_W+OFF_W-1:0]  rsp_pa
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int PA_W  = PFN_W + OFF_W;

  function automatic logic [SET_W-1:0] vpn_set(logic [VPN_W-1:0] vpn);
    return vpn[SET_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] vpn_tag(logic [VPN_W-1:0] vpn);
    return vpn[VPN_W-1 -: TAG_W];
  endfunction

  function automatic logic [PA_W-1:0] make_pa(logic [PFN_W-1:0] pfn, logic [OFF_W-1:0] off);
    return {pfn, off};
  endfunction

  // Address fields
  logic [VPN_W-1:0] lk_vpn;
  logic [SET_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;

  assign lk_vpn = lk_va[VA_W-1:OFF_W];
  assign lk_set = vpn_set(lk_vpn);
  assign lk_tag = vpn_tag(lk_vpn);
  assign fl_set = vpn_set(fill_vpn);
  assign fl_tag = vpn_tag(fill_vpn);

  // Named internal events
  way_vec_t          way_hit;
  way_vec_t          fl_match;
  way_vec_t          fl_valid;
  way_vec_t          fill_sel;
  logic              fill_accept;
  logic              lk_hit;
  logic [WAY_W-1:0]  hit_idx;
  logic [WAY_W-1:0]  fill_idx;
  logic [WAY_W-1:0]  victim;
  logic [PFN_W-1:0]  way_pfn [WAYS];
  logic [PFN_W-1:0]  hit_pfn;

  assign fill_accept = fill_valid && !flush;
  assign fill_sel    = pick_fill_way(fl_match, fl_valid, victim);
  assign fill_idx    = way_index(fill_sel);
  assign lk_hit      = |way_hit;
  assign hit_idx     = way_index(way_hit);
  assign hit_pfn     = way_pfn[hit_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way #(
      .SET_W (SET_W),
      .TAG_W (TAG_W),
      .ASID_W(ASID_W),
      .PFN_W (PFN_W)
    ) u_way (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (flush),
      .wr_en        (fill_accept && fill_sel[w]),
      .wr_set       (fl_set),
      .wr_tag       (fl_tag),
      .wr_asid      (fill_asid),
      .wr_pfn       (fill_pfn),
      .lk_set       (lk_set),
      .lk_tag       (lk_tag),
      .lk_asid      (lk_asid),
      .lk_match     (way_hit[w]),
      .lk_pfn       (way_pfn[w]),
      .wr_match     (fl_match[w]),
      .wr_slot_valid(fl_valid[w])
    );
  end

  tlb_lru #(.SET_W(SET_W)) u_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .hit_en  (lk_valid && lk_hit),
    .hit_set (lk_set),
    .hit_way (hit_idx),
    .fill_en (fill_accept),
    .fill_set(fl_set),
    .fill_way(fill_idx),
    .rd_set  (fl_set),
    .victim  (victim)
  );

  // Registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_hit;
      rsp_miss  <= lk_valid && !lk_hit;
      rsp_pa    <= (lk_valid && lk_hit) ? make_pa(hit_pfn, lk_va[OFF_W-1:0]) : '0;
    end
  end

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lk_valid,
  input logic [OFF_W-1:0]         lk_off,
  input logic                     fill_valid,
  input logic                     flush,
  input logic                     rsp_valid,
  input logic                     rsp_hit,
  input logic                     rsp_miss,
  input logic [PA_W-1:0]          rsp_pa,
  input logic [tlb_pkg::WAYS-1:0] way_hit,
  input logic [tlb_pkg::WAYS-1:0] fill_sel
);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss)); // R2

  AST_REPLY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R2

  AST_NO_STRAY_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss)); // R2

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rsp_hit || rsp_pa[OFF_W-1:0] == $past(lk_off))); // R3

  AST_MISS_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pa == '0)); // R3

  AST_SINGLE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit)); // R6

  AST_FILL_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |-> ($countones(fill_sel) == 1)); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (flush ##1 lk_valid) |=> !rsp_hit); // R8

endmodule

bind asid_tlb asid_tlb_chk #(
  .OFF_W(OFF_W),
  .PA_W (PA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_off    (lk_va[OFF_W-1:0]),
  .fill_valid(fill_valid),
  .flush     (flush),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_pa    (rsp_pa),
  .way_hit   (way_hit),
  .fill_sel  (fill_sel)
);

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid;
  logic        fill_valid;
  logic [19:0] fill_vpn;
  logic [7:0]  fill_asid;
  logic [19:0] fill_pfn;
  logic        flush;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [31:0] rsp_pa;

  always #4 clk = ~clk;

  asid_tlb uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_pa(rsp_pa)
  );

  typedef struct {
    logic        hit;
    logic [31:0] pa;
    string       req;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Physical address restated arithmetically: frame * page size + offset within page.
  function automatic logic [31:0] pa_of(logic [19:0] pfn, logic [31:0] va);
    return (32'(pfn) * 32'd4096) + (va % 32'd4096);
  endfunction

  // One driven cycle: optional lookup (with expectation), optional fill, optional flush.
  task automatic step(bit do_lk, logic [31:0] va, logic [7:0] asid, bit exp_hit,
                      logic [31:0] exp_pa, string req,
                      bit do_fill, logic [31:0] fva, logic [7:0] fasid, logic [19:0] fpfn,
                      bit do_flush);
    @(negedge clk);
    lk_valid   = do_lk;
    lk_va      = va;
    lk_asid    = asid;
    fill_valid = do_fill;
    fill_vpn   = fva[31:12];
    fill_asid  = fasid;
    fill_pfn   = fpfn;
    flush      = do_flush;
    if (do_lk) sb.push_back('{exp_hit, exp_hit ? exp_pa : 32'h0, req});
    @(negedge clk);
    lk_valid   = 1'b0;
    fill_valid = 1'b0;
    flush      = 1'b0;
  endtask

  task automatic look(logic [31:0] va, logic [7:0] asid, bit exp_hit, logic [31:0] exp_pa,
                      string req);
    step(1'b1, va, asid, exp_hit, exp_pa, req, 1'b0, 32'h0, 8'h0, 20'h0, 1'b0);
  endtask

  task automatic fill(logic [31:0] va, logic [7:0] asid, logic [19:0] pfn);
    step(1'b0, 32'h0, 8'h0, 1'b0, 32'h0, "", 1'b1, va, asid, pfn, 1'b0);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", "response without request", 32'(rsp_valid), 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(rsp_hit == e.hit, e.req, "rsp_hit", 32'(rsp_hit), 32'(e.hit));
          check(rsp_miss == !e.hit, e.req, "rsp_miss", 32'(rsp_miss), 32'(!e.hit));
          check(rsp_pa == e.pa, e.req, "rsp_pa", rsp_pa, e.pa);
        end
      end else begin
        check(!rsp_hit && !rsp_miss, "R2", "idle outcome flags", {30'h0, rsp_hit, rsp_miss}, 32'h0);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_va = '0; lk_asid = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_asid = '0; fill_pfn = '0; flush = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state of the outputs
    check(rsp_valid == 0, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
    check(rsp_hit == 0 && rsp_miss == 0, "R1", "flags in reset", {30'h0, rsp_hit, rsp_miss}, 32'h0);
    check(rsp_pa == 0, "R1", "rsp_pa in reset", rsp_pa, 32'h0);
    rst_n = 1'b1;

    // R1: empty after reset
    look(32'hDEADBEEF, 8'd1, 1'b0, 32'h0, "R1");
    look(32'h00000000, 8'd0, 1'b0, 32'h0, "R1");

    // R3: translation formula
    fill(32'hDEADBEEF, 8'd1, 20'h01234);
    look(32'hDEADBEEF, 8'd1, 1'b1, pa_of(20'h01234, 32'hDEADBEEF), "R3");
    look(32'hDEADB000, 8'd1, 1'b1, 32'h01234000, "R3");

    // R5: identifier separation
    look(32'hDEADBEEF, 8'd2, 1'b0, 32'h0, "R5");
    fill(32'hDEADBEEF, 8'd2, 20'h05555);
    look(32'hDEADBEEF, 8'd1, 1'b1, pa_of(20'h01234, 32'hDEADBEEF), "R5");
    look(32'hDEADBEEF, 8'd2, 1'b1, pa_of(20'h05555, 32'hDEADBEEF), "R5");

    // R4: page boundary and set/tag split
    fill(32'h00006000, 8'd3, 20'h00ABC);
    look(32'h00006FFF, 8'd3, 1'b1, 32'h00ABCFFF, "R4");
    look(32'h00007000, 8'd3, 1'b0, 32'h0, "R4");
    look(32'h00006000, 8'd3, 1'b1, 32'h00ABC000, "R3");
    fill(32'h9ABCD000, 8'd0, 20'h11111);
    look(32'h9ABCD123, 8'd0, 1'b1, 32'h11111123, "R4");
    look(32'h9ABCE000, 8'd0, 1'b0, 32'h0, "R4");
    look(32'h8ABCD000, 8'd0, 1'b0, 32'h0, "R4");

    // R6: duplicate fill rewrites in place, partner way untouched
    fill(32'hDEADB000, 8'd1, 20'h0AAAA);
    look(32'hDEADBEEF, 8'd1, 1'b1, pa_of(20'h0AAAA, 32'hDEADBEEF), "R6");
    look(32'hDEADBEEF, 8'd2, 1'b1, pa_of(20'h05555, 32'hDEADBEEF), "R6");

    // R7: recency-driven eviction; last hit was identifier 2 (way 1), so way 0 goes
    fill(32'hDEADBEEF, 8'd4, 20'h04444);
    look(32'hDEADBEEF, 8'd1, 1'b0, 32'h0, "R7");
    look(32'hDEADBEEF, 8'd2, 1'b1, pa_of(20'h05555, 32'hDEADBEEF), "R7");
    // the hit above marks way 1 recent, so the next fill evicts identifier 4
    fill(32'hDEADBEEF, 8'd5, 20'h05050);
    look(32'hDEADBEEF, 8'd4, 1'b0, 32'h0, "R7");
    look(32'hDEADBEEF, 8'd2, 1'b1, pa_of(20'h05555, 32'hDEADBEEF), "R7");
    look(32'hDEADBEEF, 8'd5, 1'b1, pa_of(20'h05050, 32'hDEADBEEF), "R7");

    // R9: lookup sharing a cycle with a fill sees the old contents
    step(1'b1, 32'h12345000, 8'd6, 1'b0, 32'h0, "R9", 1'b1, 32'h12345000, 8'd6, 20'h0BEEF, 1'b0);
    look(32'h12345ABC, 8'd6, 1'b1, 32'h0BEEFABC, "R9");

    // R8 + R9: flush with a concurrent fill and lookup
    step(1'b1, 32'h9ABCD000, 8'd0, 1'b1, 32'h11111000, "R9", 1'b1, 32'h55555000, 8'd7, 20'h07777, 1'b1);
    look(32'h9ABCD000, 8'd0, 1'b0, 32'h0, "R8");
    look(32'h00006000, 8'd3, 1'b0, 32'h0, "R8");
    look(32'hDEADBEEF, 8'd5, 1'b0, 32'h0, "R8");
    look(32'h55555000, 8'd7, 1'b0, 32'h0, "R8");
    fill(32'h00006000, 8'd3, 20'h00DEF);
    look(32'h00006010, 8'd3, 1'b1, 32'h00DEF010, "R8");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2", "responses outstanding", 32'(sb.size()), 32'h0);
    finish_run();
  end

endmodule